// File: doc/BRIEF.md
# Four-Channel Down-Counting Timer Block

This block holds four independent 32-bit down-counters behind one small register port. Each counter has a control byte that turns it on, picks a tick divider of 1, 16 or 256, picks a 16-bit or 32-bit counting range, and selects what happens when it runs out. The choices are to wrap to all ones, to reload from a shadow value, or to stop at zero. Every counter reaching zero latches a status bit. The status bits are masked and then merged into one interrupt line.

Counting advances only on clock cycles where the `tick_en` input is high. Tie it high to count at the system clock rate. A value written to a counter's start register is not copied into the counter at once. It is held pending and copied on the next cycle with `tick_en` high. A value written to the shadow register waits for the next wrap. Software can therefore set up the next period while the current one is still running.

Register map, as byte offsets with 32-bit words:
- 0x00: interrupt mask.
- 0x04: raw status.
- 0x08: masked status.
- 0x0C: write-one-to-clear.
- Counter c occupies 0x10 + 0x10·c. Its start value is at +0x0, its current count at +0x4, its control at +0x8 and its shadow value at +0xC.

Top module: `quad_down_timer`

## Requirements
- R1: After reset, every register reads 0, every counter is disabled, 16-bit, free-running and divided by 1, and `irq` is low.
- R2: A write to a counter's start register (+0x0) also writes its shadow register (+0xC). The current count does not change until the next clock edge with `tick_en` high, whether the counter is enabled or not.
- R3: A write to the shadow register alone leaves the current count untouched until the counter next wraps.
- R4: Control bit 7 enables counting. A disabled counter holds its value.
- R5: Control bits 3:2 set the divider: 00 decrements on every `tick_en` cycle, 01 on every 16th and 10 on every 256th. Code 11 behaves as 10.
- R6: Control bit 1 set gives 32-bit counting. When it is clear, only the low 16 bits count and the upper 16 bits of the current count read as 0.
- R7: In free-running mode (bits 6 and 0 clear), a tick at zero wraps the count to all ones of the selected width.
- R8: In periodic mode (bit 6 set, bit 0 clear), a tick at zero reloads the count from the shadow register.
- R9: Control bit 0 selects one-shot mode. It overrides bit 6, and the count stops at zero until it is reloaded.
- R10: A decrement that reaches zero sets raw status bit c. Writing 1 to bit c of 0x0C clears it, and writing 0 leaves it unchanged.
- R11: Masked status (0x08) equals raw AND mask. `irq` is high exactly when any masked bit is set.
- R12: The current-count, raw and masked registers ignore writes. A read returns the addressed register one clock after the address is presented.
- R13: Any control write restarts that counter's divider, so the next decrement comes a full divider period later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_en | input | 1 | Count enable; counting and pending start loads advance only when high |
| reg_addr | input | 8 | Byte address of the register |
| reg_wr | input | 1 | Write strobe for one cycle |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, registered one cycle after `reg_addr` |
| irq | output | 1 | OR of the masked status bits |

## Verification
A wrong divider phase shows up as a count that is off by one after a known number of `tick_en` cycles. For this reason the directed tests read counters at the exact edges of a divider period. A mishandled pending-load flag shows up within one tick as a count that changes too early or never takes the start value. A wrong wrap mode is visible on the very next tick after zero, either as an all-ones value, the shadow value or a held zero. Status faults reach `irq` in the same cycle as the decrement to zero, so each interrupt check follows directly after the tick that causes it.

// File: rtl/qdt_pkg.sv
// Package: shared constants and types of the four-channel down-counter block.
// Assumes 32-bit register words and an 8-bit control byte per counter.
package qdt_pkg;
    localparam int CTRL_W   = 8;
    localparam int PSC_W    = 8;
    localparam int B_EN     = 7;
    localparam int B_PER    = 6;
    localparam int B_PSC_LO = 2;
    localparam int B_WIDE   = 1;
    localparam int B_ONE    = 0;
    localparam logic [CTRL_W-1:0] CTRL_KEEP = 8'hCF;

    typedef enum logic [1:0] {
        PSC_DIV1   = 2'b00,
        PSC_DIV16  = 2'b01,
        PSC_DIV256 = 2'b10,
        PSC_SPARE  = 2'b11
    } psc_sel_e;

    // word select inside a counter group
    typedef enum logic [1:0] {
        SUB_START = 2'd0,
        SUB_COUNT = 2'd1,
        SUB_CTRL  = 2'd2,
        SUB_SHADOW = 2'd3
    } sub_e;

    // word select inside the shared group
    localparam logic [1:0] SH_MASK  = 2'd0;
    localparam logic [1:0] SH_RAW   = 2'd1;
    localparam logic [1:0] SH_MSKD  = 2'd2;
    localparam logic [1:0] SH_CLEAR = 2'd3;
endpackage

// File: rtl/qdt_prescaler.sv
// Module: divider for one counter. Emits a one-cycle fire pulse every 1, 16
// or 256 run cycles. Assumes restart has priority over run and PSC_W >= 8.
module qdt_prescaler
    import qdt_pkg::*;
#(
    parameter int W = PSC_W
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     restart,
    input  logic     run,
    input  psc_sel_e sel,
    output logic     fire
);
    logic [W-1:0] div_q;
    logic [W-1:0] limit;

    // terminal phase for the selected divider
    always_comb begin
        case (sel)
            PSC_DIV1:  limit = '0;
            PSC_DIV16: limit = W'(15);
            default:   limit = W'(255);
        endcase
    end

    assign fire = run && (div_q == limit);

    // phase counter: cleared on restart, advanced on run cycles
    always_ff @(posedge clk) begin
        if (!rst_n)       div_q <= '0;
        else if (restart) div_q <= '0;
        else if (run)     div_q <= fire ? '0 : div_q + W'(1);
    end
endmodule

// File: rtl/qdt_channel.sv
// Module: one down-counter with start, shadow and control registers.
// A start write is held pending until the next tick_en cycle. At zero the
// counter stops (one-shot), reloads the shadow value (periodic) or wraps to
// all ones. Assumes the write strobes are mutually exclusive.
module qdt_channel
    import qdt_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic              wr_start,
    input  logic              wr_ctrl,
    input  logic              wr_shadow,
    input  logic [DW-1:0]     wdata,
    output logic [DW-1:0]     start_q,
    output logic [DW-1:0]     shadow_q,
    output logic [DW-1:0]     count_view,
    output logic [CTRL_W-1:0] ctrl_q,
    output logic              pend_q,
    output logic              zero_hit
);
    localparam int HALF = DW / 2;

    logic [DW-1:0] cnt_q;
    logic [DW-1:0] wmask;
    logic [DW-1:0] eff;
    logic          en;
    logic          fire;
    logic          apply;
    logic          step;

    assign en         = ctrl_q[B_EN];
    assign wmask      = ctrl_q[B_WIDE] ? {DW{1'b1}} : {{(DW-HALF){1'b0}}, {HALF{1'b1}}};
    assign eff        = cnt_q & wmask;
    assign apply      = pend_q && tick_en;
    assign step       = en && tick_en && fire && !apply;
    assign zero_hit   = step && (eff == DW'(1));
    assign count_view = eff;

    qdt_prescaler #(.W(PSC_W)) i_psc (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (wr_ctrl),
        .run     (en && tick_en),
        .sel     (psc_sel_e'(ctrl_q[B_PSC_LO +: 2])),
        .fire    (fire)
    );

    // control byte, unused bits kept at zero
    always_ff @(posedge clk) begin
        if (!rst_n)       ctrl_q <= '0;
        else if (wr_ctrl) ctrl_q <= wdata[CTRL_W-1:0] & CTRL_KEEP;
    end

    // start and shadow registers; a start write updates both
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_q  <= '0;
            shadow_q <= '0;
        end else if (wr_start) begin
            start_q  <= wdata;
            shadow_q <= wdata;
        end else if (wr_shadow) begin
            shadow_q <= wdata;
        end
    end

    // pending-start flag: set by a start write, consumed on a tick_en cycle
    always_ff @(posedge clk) begin
        if (!rst_n)        pend_q <= 1'b0;
        else if (wr_start) pend_q <= 1'b1;
        else if (tick_en)  pend_q <= 1'b0;
    end

    // counter: pending start first, then a decrement or an end-of-count action
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (apply) begin
            cnt_q <= start_q;
        end else if (step) begin
            if (eff != '0)               cnt_q <= (eff - DW'(1)) & wmask;
            else if (ctrl_q[B_ONE])      cnt_q <= cnt_q;
            else if (ctrl_q[B_PER])      cnt_q <= shadow_q;
            else                         cnt_q <= wmask;
        end
    end
endmodule

// File: rtl/qdt_irq.sv
// Module: shared status logic. Latches per-counter zero events, applies the
// mask and merges into one line. A set in the same cycle as a clear wins.
module qdt_irq #(
    parameter int N_CH = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [N_CH-1:0] set_v,
    input  logic            wr_mask,
    input  logic            wr_clear,
    input  logic [N_CH-1:0] wbits,
    output logic [N_CH-1:0] raw_q,
    output logic [N_CH-1:0] mask_q,
    output logic [N_CH-1:0] masked,
    output logic            irq
);
    logic [N_CH-1:0] clr_v;

    assign clr_v  = wr_clear ? wbits : '0;
    assign masked = raw_q & mask_q;
    assign irq    = |masked;

    // sticky raw status with write-one-to-clear
    always_ff @(posedge clk) begin
        if (!rst_n) raw_q <= '0;
        else        raw_q <= (raw_q & ~clr_v) | set_v;
    end

    // interrupt mask register
    always_ff @(posedge clk) begin
        if (!rst_n)       mask_q <= '0;
        else if (wr_mask) mask_q <= wbits;
    end
endmodule

// File: rtl/quad_down_timer.sv
// Module: top of the four-channel down-counter block. Decodes the register
// port, holds the counters and the shared status logic, and registers the
// read data. Assumes one access per cycle and reads with no side effects.
module quad_down_timer
    import qdt_pkg::*;
#(
    parameter int N_CH = 4,
    parameter int DW   = 32,
    parameter int AW   = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick_en,
    input  logic [AW-1:0] reg_addr,
    input  logic          reg_wr,
    input  logic [DW-1:0] reg_wdata,
    output logic [DW-1:0] reg_rdata,
    output logic          irq
);
    localparam int GW = AW - 4;

    logic [GW-1:0]        grp;
    logic [1:0]           sub;
    logic                 sh_sel;
    logic [N_CH-1:0]      ch_sel;
    logic [N_CH-1:0]      zero_v;
    logic [N_CH-1:0]      pend_v;
    logic [N_CH-1:0]      raw_v;
    logic [N_CH-1:0]      mask_v;
    logic [N_CH-1:0]      mskd_v;
    logic [DW-1:0]        ch_start  [N_CH];
    logic [DW-1:0]        ch_shadow [N_CH];
    logic [DW-1:0]        ch_count  [N_CH];
    logic [CTRL_W-1:0]    ch_ctrl   [N_CH];
    logic [N_CH*DW-1:0]   count_flat;
    logic [N_CH*CTRL_W-1:0] ctrl_flat;
    logic [DW-1:0]        rd_nxt;

    assign grp    = reg_addr[AW-1:4];
    assign sub    = reg_addr[3:2];
    assign sh_sel = (grp == '0);

    generate
        for (genvar c = 0; c < N_CH; c++) begin : g_ch
            assign ch_sel[c] = (grp == GW'(c + 1));

            qdt_channel #(.DW(DW)) i_ch (
                .clk        (clk),
                .rst_n      (rst_n),
                .tick_en    (tick_en),
                .wr_start   (reg_wr && ch_sel[c] && sub == SUB_START),
                .wr_ctrl    (reg_wr && ch_sel[c] && sub == SUB_CTRL),
                .wr_shadow  (reg_wr && ch_sel[c] && sub == SUB_SHADOW),
                .wdata      (reg_wdata),
                .start_q    (ch_start[c]),
                .shadow_q   (ch_shadow[c]),
                .count_view (ch_count[c]),
                .ctrl_q     (ch_ctrl[c]),
                .pend_q     (pend_v[c]),
                .zero_hit   (zero_v[c])
            );

            assign count_flat[c*DW +: DW]         = ch_count[c];
            assign ctrl_flat[c*CTRL_W +: CTRL_W]  = ch_ctrl[c];
        end
    endgenerate

    qdt_irq #(.N_CH(N_CH)) i_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_v    (zero_v),
        .wr_mask  (reg_wr && sh_sel && sub == SH_MASK),
        .wr_clear (reg_wr && sh_sel && sub == SH_CLEAR),
        .wbits    (reg_wdata[N_CH-1:0]),
        .raw_q    (raw_v),
        .mask_q   (mask_v),
        .masked   (mskd_v),
        .irq      (irq)
    );

    // read multiplexer over the shared and per-counter words
    always_comb begin
        rd_nxt = '0;
        if (sh_sel) begin
            case (sub)
                SH_MASK: rd_nxt = DW'(mask_v);
                SH_RAW:  rd_nxt = DW'(raw_v);
                SH_MSKD: rd_nxt = DW'(mskd_v);
                default: rd_nxt = '0;
            endcase
        end
        for (int c = 0; c < N_CH; c++) begin
            if (ch_sel[c]) begin
                case (sub)
                    SUB_START: rd_nxt = ch_start[c];
                    SUB_COUNT: rd_nxt = ch_count[c];
                    SUB_CTRL:  rd_nxt = DW'(ch_ctrl[c]);
                    default:   rd_nxt = ch_shadow[c];
                endcase
            end
        end
    end

    // registered read data
    always_ff @(posedge clk) begin
        if (!rst_n) reg_rdata <= '0;
        else        reg_rdata <= rd_nxt;
    end
endmodule

// File: rtl/qdt_checker.sv
// Module: property checker for quad_down_timer, attached by bind.
// Assumes the flat count and control vectors hold channel c at slice c.
module qdt_checker #(
    parameter int N_CH = 4,
    parameter int DW   = 32,
    parameter int AW   = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tick_en,
    input logic              reg_wr,
    input logic [AW-1:0]     reg_addr,
    input logic [DW-1:0]     reg_wdata,
    input logic [N_CH*DW-1:0] count_flat,
    input logic [N_CH*8-1:0] ctrl_flat,
    input logic [N_CH-1:0]   pend_v,
    input logic [N_CH-1:0]   raw_v,
    input logic              irq
);
    localparam logic [AW-1:0] A_CLEAR = AW'(12);

    // R2: with no tick and no access, no count moves
    a_r2_quiet_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_en && !reg_wr) |=> $stable(count_flat));

    // R10: clearing all bits in a tickless cycle empties raw status
    a_r10_clear_all: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == A_CLEAR && (&reg_wdata[N_CH-1:0]) && !tick_en) |=> (raw_v == '0));

    // R11: interrupt only with some raw bit set
    a_r11_irq_needs_raw: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (raw_v != '0));

    generate
        for (genvar c = 0; c < N_CH; c++) begin : g_chk
            // R10: raw bit stays set until a clear write
            a_r10_raw_sticky: assert property (@(posedge clk) disable iff (!rst_n)
                (raw_v[c] && !(reg_wr && reg_addr == A_CLEAR)) |=> raw_v[c]);

            // R9: a one-shot counter at zero stays at zero
            a_r9_oneshot_hold: assert property (@(posedge clk) disable iff (!rst_n)
                (ctrl_flat[c*8+7] && ctrl_flat[c*8] && count_flat[c*DW +: DW] == '0
                 && !pend_v[c] && !reg_wr) |=> (count_flat[c*DW +: DW] == '0));

            // R4: a disabled counter without pending start holds its value
            a_r4_disabled_hold: assert property (@(posedge clk) disable iff (!rst_n)
                (!ctrl_flat[c*8+7] && !pend_v[c] && !reg_wr) |=> $stable(count_flat[c*DW +: DW]));
        end
    endgenerate
endmodule

bind quad_down_timer qdt_checker #(.N_CH(N_CH), .DW(DW), .AW(AW)) i_qdt_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick_en    (tick_en),
    .reg_wr     (reg_wr),
    .reg_addr   (reg_addr),
    .reg_wdata  (reg_wdata),
    .count_flat (count_flat),
    .ctrl_flat  (ctrl_flat),
    .pend_v     (pend_v),
    .raw_v      (raw_v),
    .irq        (irq)
);

// File: tb/test_quad_down_timer.sv
// Directed bench for quad_down_timer: one task per scenario, each checking
// its own results through the register port and the irq pin.
module test_quad_down_timer;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_en = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic        reg_wr = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq;
    int          total = 0;
    int          bad = 0;
    logic [31:0] v;

    always #(CLK_PERIOD/2) clk = ~clk;

    quad_down_timer i_quad_down_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_en   (tick_en),
        .reg_addr  (reg_addr),
        .reg_wr    (reg_wr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .irq       (irq)
    );

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        reg_addr = a;
        @(negedge clk);
        d = reg_rdata;
    endtask

    task automatic tick(input int n);
        tick_en = 1'b1;
        repeat (n) @(negedge clk);
        tick_en = 1'b0;
    endtask

    // stop channel 0, give it a start value and let it land
    task automatic prep0(input logic [31:0] s);
        wr(8'h18, 32'h0);
        wr(8'h10, s);
        tick(1);
    endtask

    task automatic t_reset;
        rd(8'h18, v); check("R1 ctrl0", v, 32'h0);
        rd(8'h14, v); check("R1 count0", v, 32'h0);
        rd(8'h00, v); check("R1 mask", v, 32'h0);
        check("R1 irq", {31'b0, irq}, 32'h0);
    endtask

    task automatic t_start_delay;
        wr(8'h10, 32'd100);
        rd(8'h14, v); check("R2 count before tick", v, 32'h0);
        tick(1);
        rd(8'h14, v); check("R2 count after tick", v, 32'd100);
        rd(8'h1C, v); check("R2 shadow follows start", v, 32'd100);
    endtask

    task automatic t_disabled;
        wr(8'h18, 32'h02);
        tick(5);
        rd(8'h14, v); check("R4 disabled holds", v, 32'd100);
    endtask

    task automatic t_read_only;
        wr(8'h14, 32'hDEAD);
        wr(8'h04, 32'hF);
        wr(8'h08, 32'hF);
        rd(8'h14, v); check("R12 count ignores write", v, 32'd100);
        rd(8'h04, v); check("R12 raw ignores write", v, 32'h0);
        rd(8'h08, v); check("R12 masked ignores write", v, 32'h0);
    endtask

    task automatic t_div1;
        prep0(32'd10);
        wr(8'h18, 32'h82);
        tick(5);
        rd(8'h14, v); check("R5 div1 five ticks", v, 32'd5);
    endtask

    task automatic t_div16;
        wr(8'h0C, 32'hF);
        prep0(32'd3);
        wr(8'h18, 32'h86);
        tick(32);
        rd(8'h14, v); check("R5 div16 two periods", v, 32'd1);
        tick(15);
        rd(8'h14, v); check("R5 div16 short of period", v, 32'd1);
        tick(1);
        rd(8'h14, v); check("R5 div16 reaches zero", v, 32'd0);
        rd(8'h04, v); check("R10 raw set at zero", v, 32'h1);
    endtask

    task automatic t_div256;
        prep0(32'd2);
        wr(8'h18, 32'h8A);
        tick(255);
        rd(8'h14, v); check("R5 div256 short of period", v, 32'd2);
        tick(1);
        rd(8'h14, v); check("R5 div256 one period", v, 32'd1);
    endtask

    task automatic t_psc_restart;
        prep0(32'd8);
        wr(8'h18, 32'h86);
        tick(10);
        wr(8'h18, 32'h86);
        tick(15);
        rd(8'h14, v); check("R13 divider restarted", v, 32'd8);
        tick(1);
        rd(8'h14, v); check("R13 full period after restart", v, 32'd7);
    endtask

    task automatic t_periodic;
        wr(8'h0C, 32'hF);
        prep0(32'd5);
        wr(8'h18, 32'hC2);
        tick(2);
        wr(8'h1C, 32'd9);
        rd(8'h14, v); check("R3 shadow waits for wrap", v, 32'd3);
        tick(3);
        rd(8'h14, v); check("R8 at zero", v, 32'd0);
        rd(8'h04, v); check("R10 raw on periodic zero", v, 32'h1);
        tick(1);
        rd(8'h14, v); check("R8 reload from shadow", v, 32'd9);
    endtask

    task automatic t_free_run;
        prep0(32'h0001_0001);
        rd(8'h14, v); check("R6 upper half zero in 16-bit", v, 32'h1);
        wr(8'h18, 32'h80);
        tick(2);
        rd(8'h14, v); check("R7 16-bit wrap", v, 32'h0000_FFFF);
        prep0(32'd1);
        wr(8'h18, 32'h82);
        tick(2);
        rd(8'h14, v); check("R7 32-bit wrap", v, 32'hFFFF_FFFF);
    endtask

    task automatic t_one_shot;
        wr(8'h0C, 32'hF);
        prep0(32'd2);
        wr(8'h18, 32'hC3);
        tick(6);
        rd(8'h14, v); check("R9 one-shot stops at zero", v, 32'd0);
        rd(8'h04, v); check("R10 raw on one-shot", v, 32'h1);
    endtask

    task automatic t_irq;
        wr(8'h00, 32'h0);
        check("R11 masked off no irq", {31'b0, irq}, 32'h0);
        rd(8'h08, v); check("R11 masked status off", v, 32'h0);
        wr(8'h00, 32'h1);
        check("R11 irq raised", {31'b0, irq}, 32'h1);
        rd(8'h08, v); check("R11 masked status on", v, 32'h1);
        wr(8'h0C, 32'h0);
        rd(8'h04, v); check("R10 zero write keeps raw", v, 32'h1);
        wr(8'h0C, 32'h1);
        check("R10 irq cleared", {31'b0, irq}, 32'h0);
        rd(8'h04, v); check("R10 raw cleared", v, 32'h0);
    endtask

    task automatic t_channel3;
        wr(8'h48, 32'h0);
        wr(8'h40, 32'd4);
        tick(1);
        wr(8'h48, 32'h82);
        wr(8'h00, 32'h8);
        tick(4);
        rd(8'h44, v); check("R12 channel 3 count", v, 32'd0);
        rd(8'h04, v); check("R10 only channel 3 raw", v, 32'h8);
        check("R11 irq from channel 3", {31'b0, irq}, 32'h1);
        rd(8'h14, v); check("R9 channel 0 still held", v, 32'd0);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_start_delay();
        t_disabled();
        t_read_only();
        t_div1();
        t_div16();
        t_div256();
        t_psc_restart();
        t_periodic();
        t_free_run();
        t_one_shot();
        t_irq();
        t_channel3();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule